// File: doc/BRIEF.md
# Zero-Suppressed Three-Level Hit Recorder

This block sits behind a 64-channel detector front end. Each channel delivers three latched comparator levels, one for each of three thresholds. The levels are reduced to a 2-bit amplitude class. When a channel's enabled levels go from all-low to any-high, the channel writes one record into its own eight-entry queue. The record holds the amplitude class and the value of a shared 12-bit bunch-crossing counter. The channels never wait on each other. Any number of them may capture in the same clock cycle.

A readout frame is started by a one-cycle request. The frame walks the channels from index 0 upward and drains every record that each channel holds, oldest first. Channels with empty queues produce no output words. Words leave through a valid/ready handshake. A one-cycle end marker closes the frame. Each channel has a slow-control enable bit that silences a noisy input. A sticky per-channel flag reports records that were lost because a queue was full. An acquisition-start pulse restarts the crossing counter and clears the loss flags.

Top module: `hitrec_top`

## Requirements
- R1: The amplitude class is taken from the highest asserted level: level 2 gives 2'b11, level 1 without level 2 gives 2'b10, and level 0 alone gives 2'b01. This holds for any combination, thermometer or not.
- R2: A channel captures exactly one record in the cycle where the OR of its enabled levels rises. While the levels stay high, nothing more is captured.
- R3: The crossing counter advances by one every clock cycle and wraps from 4095 to 0.
- R4: When a capture happens in the same cycle as acq_start, the record holds crossing 0. A capture in the following cycle holds crossing 1.
- R5: While a channel's bit in chan_en is 0, that channel captures no record and never sets its loss flag.
- R6: Each channel keeps at most 8 records. A capture into a full queue is dropped and sets that channel's bit in ovf_flag. The bit stays set until acq_start or reset.
- R7: A frame visits channels in ascending index order and emits every record of a channel, oldest first, before moving on. No word is emitted for a channel with an empty queue.
- R8: An output word is {channel[19:14], crossing[13:2], class[1:0]}.
- R9: While rd_valid is high and rd_ready is low, rd_valid stays high and rd_data does not change on the next cycle. A record is removed only when rd_valid and rd_ready are both high at a clock edge.
- R10: After the last channel has been visited, rd_eof is high for exactly one cycle, with rd_valid low. rd_eof is low outside that cycle.
- R11: Captures on several channels in the same cycle are all stored, and each carries the same crossing value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_start | input | 1 | Restarts the crossing counter and clears the loss flags |
| chan_en | input | 64 | Per-channel capture enable |
| thr_in | input | 192 | Latched levels; channel c uses bits [3c+2:3c], with bit 3c as the lowest threshold |
| rd_start | input | 1 | One-cycle frame request, ignored while a frame is running |
| rd_ready | input | 1 | Sink accepts the current word |
| rd_valid | output | 1 | Output word valid |
| rd_data | output | 20 | Output word |
| rd_eof | output | 1 | Frame end marker |
| ovf_flag | output | 64 | Sticky per-channel loss flags |

## Verification
The amplitude encoder is driven with all seven non-zero level patterns on one channel. This separates the highest-level rule from a plain priority or a population count. A level held high for many cycles tells edge capture apart from level capture. Simultaneous hits on the first, middle and last channels expose both ordering errors and missing channels. A queue overfilled by two extra hits, a disabled channel and an empty frame cover dropping and zero suppression. A clear that coincides with a hit, followed by a full wrap of the counter, pins down the crossing values. A throttled sink checks that the output holds steady under back-pressure.

// File: rtl/hitrec_pkg.sv
package hitrec_pkg;

    localparam int NUM_CH     = 64;
    localparam int CH_W       = $clog2(NUM_CH);
    localparam int N_THR      = 3;
    localparam int BCID_W     = 12;
    localparam int CODE_W     = 2;
    localparam int FIFO_DEPTH = 8;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [BCID_W-1:0] bcid_t;
    typedef logic [CH_W-1:0]   chan_t;

    typedef struct packed {
        bcid_t bcid;
        code_t code;
    } hit_rec_t;

    typedef struct packed {
        chan_t chan;
        bcid_t bcid;
        code_t code;
    } rd_word_t;

    localparam int WORD_W = $bits(rd_word_t);

    typedef enum logic [1:0] {
        SC_IDLE,
        SC_SCAN,
        SC_END
    } scan_state_t;

    // Highest asserted level wins, whatever the lower bits are.
    function automatic code_t thr_encode(input logic [N_THR-1:0] lv);
        code_t c;
        if (lv[2])      c = 2'b11;
        else if (lv[1]) c = 2'b10;
        else if (lv[0]) c = 2'b01;
        else            c = 2'b00;
        return c;
    endfunction

endpackage

// File: rtl/hitrec_bcid.sv
module hitrec_bcid
    import hitrec_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  acq_start,
    output bcid_t bcid_now
);

    bcid_t cnt_q;

    // The clear takes effect in its own cycle, so a coincident hit sees zero.
    assign bcid_now = acq_start ? '0 : cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= bcid_now + bcid_t'(1);
    end

endmodule

// File: rtl/hitrec_chan.sv
module hitrec_chan
    import hitrec_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acq_start,
    input  logic             enable,
    input  logic [N_THR-1:0] thr,
    input  bcid_t            bcid_now,
    input  logic             pop,
    output logic             nonempty,
    output hit_rec_t         head,
    output logic             ovf
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    hit_rec_t   mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt;
    logic       armed_q;
    logic       gated, fire, room, do_push, do_pop, drop;

    assign gated   = enable & (|thr);
    assign fire    = gated & ~armed_q;
    assign do_pop  = pop & (cnt != '0);
    assign room    = (cnt != CNT_W'(DEPTH)) | do_pop;
    assign do_push = fire & room;
    assign drop    = fire & ~room;

    assign nonempty = (cnt != '0);
    assign head     = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr].bcid <= bcid_now;
            mem[wr_ptr].code <= thr_encode(thr);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            cnt     <= '0;
            armed_q <= 1'b0;
            ovf     <= 1'b0;
        end else begin
            armed_q <= gated;
            if (do_push) wr_ptr <= ptr_inc(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   cnt <= cnt + CNT_W'(1);
                2'b01:   cnt <= cnt - CNT_W'(1);
                default: cnt <= cnt;
            endcase
            if (acq_start) ovf <= 1'b0;
            else if (drop) ovf <= 1'b1;
        end
    end

endmodule

// File: rtl/hitrec_scan.sv
module hitrec_scan
    import hitrec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_start,
    input  logic [NUM_CH-1:0] nonempty,
    input  hit_rec_t          heads [NUM_CH],
    input  logic              rd_ready,
    output logic [NUM_CH-1:0] pop,
    output logic              rd_valid,
    output rd_word_t          rd_word,
    output logic              rd_eof
);

    scan_state_t state;
    chan_t       idx;
    logic        cur_has;

    assign cur_has  = nonempty[idx];
    assign rd_valid = (state == SC_SCAN) && cur_has;
    assign rd_eof   = (state == SC_END);

    always_comb begin
        rd_word.chan = idx;
        rd_word.bcid = heads[idx].bcid;
        rd_word.code = heads[idx].code;
        pop          = '0;
        if (rd_valid && rd_ready) pop[idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SC_IDLE;
            idx   <= '0;
        end else begin
            unique case (state)
                SC_IDLE: begin
                    if (rd_start) begin
                        state <= SC_SCAN;
                        idx   <= '0;
                    end
                end
                SC_SCAN: begin
                    // Stay on a channel until its queue is drained.
                    if (!cur_has) begin
                        if (idx == chan_t'(NUM_CH - 1)) state <= SC_END;
                        else                            idx   <= idx + chan_t'(1);
                    end
                end
                SC_END:  state <= SC_IDLE;
                default: state <= SC_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/hitrec_top.sv
module hitrec_top
    import hitrec_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    acq_start,
    input  logic [NUM_CH-1:0]       chan_en,
    input  logic [NUM_CH*N_THR-1:0] thr_in,
    input  logic                    rd_start,
    input  logic                    rd_ready,
    output logic                    rd_valid,
    output logic [WORD_W-1:0]       rd_data,
    output logic                    rd_eof,
    output logic [NUM_CH-1:0]       ovf_flag
);

    bcid_t             bcid_now;
    hit_rec_t          heads [NUM_CH];
    logic [NUM_CH-1:0] nonempty;
    logic [NUM_CH-1:0] pop;
    rd_word_t          rd_word;

    hitrec_bcid u_bcid (
        .clk       (clk),
        .rst       (rst),
        .acq_start (acq_start),
        .bcid_now  (bcid_now)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        hitrec_chan #(.DEPTH(DEPTH)) u_chan (
            .clk       (clk),
            .rst       (rst),
            .acq_start (acq_start),
            .enable    (chan_en[g]),
            .thr       (thr_in[g*N_THR +: N_THR]),
            .bcid_now  (bcid_now),
            .pop       (pop[g]),
            .nonempty  (nonempty[g]),
            .head      (heads[g]),
            .ovf       (ovf_flag[g])
        );
    end

    hitrec_scan u_scan (
        .clk      (clk),
        .rst      (rst),
        .rd_start (rd_start),
        .nonempty (nonempty),
        .heads    (heads),
        .rd_ready (rd_ready),
        .pop      (pop),
        .rd_valid (rd_valid),
        .rd_word  (rd_word),
        .rd_eof   (rd_eof)
    );

    assign rd_data = rd_word;

endmodule

// File: rtl/hitrec_checker.sv
module hitrec_checker
    import hitrec_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              acq_start,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic [WORD_W-1:0] rd_data,
    input logic              rd_eof,
    input logic [NUM_CH-1:0] ovf_flag
);

    // R9: a stalled word is held
    a_r9_hold_word: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    // R10: the end marker never overlaps a word
    a_r10_eof_alone: assert property (@(posedge clk) disable iff (rst)
        rd_eof |-> !rd_valid);

    // R10: the end marker lasts one cycle
    a_r10_eof_pulse: assert property (@(posedge clk) disable iff (rst)
        rd_eof |=> !rd_eof);

    // R6: loss flags only clear on acq_start
    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        !acq_start |=> ((ovf_flag & $past(ovf_flag)) == $past(ovf_flag)));

    // R6: acq_start clears every loss flag
    a_r6_ovf_clear: assert property (@(posedge clk) disable iff (rst)
        acq_start |=> (ovf_flag == '0));

endmodule

bind hitrec_top hitrec_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .acq_start (acq_start),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_data   (rd_data),
    .rd_eof    (rd_eof),
    .ovf_flag  (ovf_flag)
);

// File: tb/tb_hitrec_top.sv
module tb_hitrec_top;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         acq_start = 1'b0;
    logic [63:0]  chan_en = '1;
    logic [191:0] thr_in = '0;
    logic         rd_start = 1'b0;
    logic         rd_ready = 1'b0;
    logic         rd_valid;
    logic [19:0]  rd_data;
    logic         rd_eof;
    logic [63:0]  ovf_flag;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    hitrec_top dut (
        .clk(clk), .rst(rst), .acq_start(acq_start), .chan_en(chan_en),
        .thr_in(thr_in), .rd_start(rd_start), .rd_ready(rd_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_eof(rd_eof),
        .ovf_flag(ovf_flag)
    );

    // Reference model built from the requirements
    int          mcnt [64];
    int          mrd  [64];
    logic [13:0] mq   [64][8];
    logic [63:0] mprev;
    int          exp_cnt;

    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < 64; c++) begin mcnt[c] = 0; mrd[c] = 0; end
            mprev   = '0;
            exp_cnt = 0;
        end else begin
            int cur;
            cur = acq_start ? 0 : exp_cnt;
            exp_cnt = (cur + 1) % 4096;
            for (int c = 0; c < 64; c++) begin
                logic [2:0] lv;
                logic       g;
                logic [1:0] cd;
                lv = thr_in[3*c +: 3];
                g  = chan_en[c] && (lv != 3'b000);
                cd = lv[2] ? 2'd3 : lv[1] ? 2'd2 : lv[0] ? 2'd1 : 2'd0;
                if (g && !mprev[c] && mcnt[c] < 8) begin
                    mq[c][(mrd[c] + mcnt[c]) % 8] = {cur[11:0], cd};
                    mcnt[c]++;
                end
                mprev[c] = g;
            end
        end
    end

    logic [19:0] fr_data [64];
    int          fr_n;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse(input int c, input logic [2:0] lv);
        @(negedge clk);
        thr_in[3*c +: 3] = lv;
        @(negedge clk);
        thr_in[3*c +: 3] = 3'b000;
    endtask

    task automatic run_frame(input int mode);
        int last_ch = 0;
        int cyc = 0;
        int left = 0;
        bit done = 0;
        bit held_v = 0;
        logic [19:0] held = '0;
        fr_n = 0;
        @(negedge clk); rd_start = 1'b1;
        @(negedge clk); rd_start = 1'b0;
        while (!done && cyc < 3000) begin
            rd_ready = (mode == 0) || (cyc % 3 == 2);
            #1;
            if (held_v) chk(rd_valid && rd_data == held, "R9 stalled word held", int'(rd_data), int'(held));
            held_v = 0;
            if (rd_eof) begin
                chk(!rd_valid, "R10 valid low at end marker", int'(rd_valid), 0);
                done = 1;
            end else if (rd_valid) begin
                int c;
                c = int'(rd_data[19:14]);
                if (rd_ready) begin
                    chk(c >= last_ch, "R7 ascending channels", c, last_ch);
                    chk(mcnt[c] > 0, "R7 word only from a channel with records", mcnt[c], 1);
                    if (mcnt[c] > 0) begin
                        chk(rd_data[13:0] == mq[c][mrd[c]], "R8 word contents", int'(rd_data[13:0]), int'(mq[c][mrd[c]]));
                        mrd[c] = (mrd[c] + 1) % 8;
                        mcnt[c]--;
                    end
                    if (fr_n < 64) fr_data[fr_n] = rd_data;
                    fr_n++;
                    last_ch = c;
                end else begin
                    held = rd_data;
                    held_v = 1;
                end
            end
            cyc++;
            @(negedge clk);
        end
        rd_ready = 1'b0;
        chk(done, "R10 end marker seen", int'(done), 1);
        for (int c = 0; c < 64; c++) left += mcnt[c];
        chk(left == 0, "R7 every record emitted", left, 0);
    endtask

    task automatic t_reset;
        #1;
        chk(!rd_valid, "R10 no word after reset", int'(rd_valid), 0);
        chk(!rd_eof, "R10 no end marker after reset", int'(rd_eof), 0);
        chk(ovf_flag == '0, "R6 loss flags clear after reset", int'(ovf_flag[31:0]), 0);
    endtask

    task automatic t_encode;
        int exp_code [7] = '{1, 2, 2, 3, 3, 3, 3};
        for (int p = 1; p <= 7; p++) pulse(5, p[2:0]);
        run_frame(0);
        chk(fr_n == 7, "R1 one record per pattern", fr_n, 7);
        for (int i = 0; i < 7; i++)
            chk(fr_data[i][1:0] == exp_code[i][1:0], "R1 class code", int'(fr_data[i][1:0]), exp_code[i]);
    endtask

    task automatic t_level;
        @(negedge clk); thr_in[3*9 +: 3] = 3'b001;
        repeat (20) @(negedge clk);
        thr_in[3*9 +: 3] = 3'b011;
        repeat (5) @(negedge clk);
        thr_in[3*9 +: 3] = 3'b000;
        run_frame(0);
        chk(fr_n == 1, "R2 held level captured once", fr_n, 1);
    endtask

    task automatic t_multi;
        @(negedge clk);
        thr_in[3*63 +: 3] = 3'b100;
        thr_in[3*0  +: 3] = 3'b001;
        thr_in[3*30 +: 3] = 3'b010;
        thr_in[3*31 +: 3] = 3'b111;
        @(negedge clk);
        thr_in = '0;
        pulse(0, 3'b010);
        run_frame(0);
        chk(fr_n == 5, "R11 all simultaneous hits stored", fr_n, 5);
        chk(fr_data[0][19:14] == 0 && fr_data[1][19:14] == 0, "R7 channel 0 first", int'(fr_data[1][19:14]), 0);
        chk(fr_data[2][19:14] == 30 && fr_data[3][19:14] == 31 && fr_data[4][19:14] == 63,
            "R7 order 30,31,63", int'(fr_data[4][19:14]), 63);
        chk(fr_data[0][13:2] == fr_data[2][13:2] && fr_data[0][13:2] == fr_data[4][13:2],
            "R11 same crossing for same cycle", int'(fr_data[4][13:2]), int'(fr_data[0][13:2]));
        chk(fr_data[1][13:2] == fr_data[0][13:2] + 12'd2, "R3 crossing advances per cycle",
            int'(fr_data[1][13:2]), int'(fr_data[0][13:2]) + 2);
    endtask

    task automatic t_disable;
        chan_en[12] = 1'b0;
        for (int i = 0; i < 10; i++) pulse(12, 3'b111);
        pulse(13, 3'b001);
        #1;
        chk(ovf_flag[12] == 1'b0, "R5 disabled channel sets no loss flag", int'(ovf_flag[12]), 0);
        run_frame(0);
        chk(fr_n == 1 && fr_data[0][19:14] == 13, "R5 only enabled channel emits", fr_n, 1);
        chan_en[12] = 1'b1;
    endtask

    task automatic t_overflow;
        for (int i = 0; i < 10; i++) pulse(40, 3'b001);
        #1;
        chk(ovf_flag[40] == 1'b1, "R6 loss flag set on full queue", int'(ovf_flag[40]), 1);
        chk(ovf_flag[39] == 1'b0, "R6 neighbour flag untouched", int'(ovf_flag[39]), 0);
        run_frame(1);
        chk(fr_n == 8, "R6 eight records kept", fr_n, 8);
        chk(fr_data[7][13:2] == fr_data[0][13:2] + 12'd14, "R6 oldest records kept",
            int'(fr_data[7][13:2]), int'(fr_data[0][13:2]) + 14);
        #1;
        chk(ovf_flag[40] == 1'b1, "R6 loss flag sticky after readout", int'(ovf_flag[40]), 1);
        @(negedge clk); acq_start = 1'b1;
        @(negedge clk); acq_start = 1'b0;
        chk(ovf_flag == '0, "R6 acq_start clears loss flags", int'(ovf_flag[40]), 0);
    endtask

    task automatic t_bcid;
        @(negedge clk);
        acq_start = 1'b1; thr_in[3*2 +: 3] = 3'b001;
        @(negedge clk);
        acq_start = 1'b0; thr_in[3*2 +: 3] = 3'b000; thr_in[3*3 +: 3] = 3'b001;
        @(negedge clk);
        thr_in[3*3 +: 3] = 3'b000;
        repeat (4093) @(negedge clk);
        thr_in[3*5 +: 3] = 3'b010;
        @(negedge clk);
        thr_in[3*5 +: 3] = 3'b000; thr_in[3*4 +: 3] = 3'b100;
        @(negedge clk);
        thr_in[3*4 +: 3] = 3'b000;
        run_frame(0);
        chk(fr_n == 4, "R3 four records", fr_n, 4);
        chk(fr_data[0][13:2] == 12'd0, "R4 hit with clear gets 0", int'(fr_data[0][13:2]), 0);
        chk(fr_data[1][13:2] == 12'd1, "R4 next cycle gets 1", int'(fr_data[1][13:2]), 1);
        chk(fr_data[2][13:2] == 12'd0, "R3 wrap to 0", int'(fr_data[2][13:2]), 0);
        chk(fr_data[3][13:2] == 12'd4095, "R3 last value 4095", int'(fr_data[3][13:2]), 4095);
    endtask

    task automatic t_backpressure;
        @(negedge clk);
        thr_in[3*1 +: 3] = 3'b001; thr_in[3*50 +: 3] = 3'b011;
        @(negedge clk);
        thr_in = '0;
        pulse(1, 3'b100);
        pulse(50, 3'b001);
        run_frame(1);
        chk(fr_n == 4, "R9 all words delivered under stall", fr_n, 4);
    endtask

    task automatic t_empty;
        run_frame(0);
        chk(fr_n == 0, "R7 empty frame has no words", fr_n, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_encode();
        t_level();
        t_multi();
        t_disable();
        t_overflow();
        t_bcid();
        t_backpressure();
        t_empty();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule